// File: doc/BRIEF.md
# ADC Result Gain and Offset Corrector

This block sits between a converter and the rest of a measurement chain and trims each raw signed 16-bit conversion result with a programmable offset and gain. Two classes of input are recognised: the high-speed transimpedance path, which has a dedicated gain coefficient and no offset, and the auxiliary voltage path, which has its own gain and offset coefficient pair. A one-bit class tag accompanies every sample and picks the coefficient set.

Coefficients sit in three small registers reached through a plain word-wide write/read port. The corrected result leaves a two-stage pipeline, rounded to the nearest integer and clamped to the signed 16-bit range, with a valid flag that travels alongside the data. The class tag and the coefficients in force are captured with the sample, so later register writes only affect later samples.

Top module: `adc_cal_path`

## Requirements
- R1: After reset, reading address 0 (transimpedance gain) and address 1 (auxiliary gain) returns 0x00004000, and address 2 (auxiliary offset) returns 0x00000000; address 3 reads 0.
- R2: A write stores only bits [14:0] of the write data into the addressed register at the next clock edge; bits [31:15] always read as zero.
- R3: With gain code 0x4000 and zero offset, the output equals the input sample on both channel classes (in_chan 0 = transimpedance, 1 = auxiliary).
- R4: The auxiliary offset is a 15-bit two's-complement value in quarter-LSB units (0x0001 = +0.25, 0x7FFF = -0.25, 0x4000 = -4096, 0x3FFF = +4095.75) added before scaling; transimpedance samples never receive an offset.
- R5: The gain code is an unsigned 15-bit multiplier in units of 1/16384 (0x2000 = 0.5, 0x7FFF is just under 2, 0x0001 is the smallest step), applied to (4 x sample + offset) followed by division by 65536.
- R6: The quotient is rounded to nearest, with exact halves rounded away from zero.
- R7: Results above 32767 clamp to 0x7FFF and results below -32768 clamp to 0x8000.
- R8: Gain code 0x0000 forces the output to 0x0000 on the transimpedance class and to 0x8000 on the auxiliary class.
- R9: A sample presented with in_valid high at one clock edge appears with out_valid high after the second following edge; out_valid is low otherwise and out_data holds its value while out_valid is low.
- R10: The class tag and the coefficients are those in force at the edge where the sample is accepted; a register write at that same edge or later affects only later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 TIA gain, 1 aux gain, 2 aux offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| in_valid | input | 1 | Input sample valid |
| in_chan | input | 1 | Class tag: 0 transimpedance, 1 auxiliary |
| in_sample | input | 16 | Raw signed conversion result |
| out_valid | output | 1 | Corrected result valid |
| out_data | output | 16 | Corrected signed result |

## Verification
On every cycle the assertions check that a write lands in the addressed coefficient at the next edge, that the valid flag advances exactly one stage per edge and the output holds when idle, that transimpedance samples enter the pipeline without offset, that unity gain passes transimpedance samples through, and that a zero gain code forces the class-dependent constant. Rounding of exact halves, clamping at both rails, the quarter-LSB offset weighting, and the capture of coefficients at acceptance time only show up in the bench's directed scenarios and its random stream checked against an arithmetic model.

// File: rtl/adccal_pkg.sv
package adccal_pkg;

    parameter int SAMPLE_W  = 16;
    parameter int COEF_W    = 15;
    parameter int OFF_FRAC  = 2;
    parameter int GAIN_FRAC = 14;
    parameter int WORD_W    = 32;
    parameter int ADDR_W    = 2;

    localparam int EXT_W   = SAMPLE_W + OFF_FRAC + 1;
    localparam int PROD_W  = EXT_W + COEF_W + 1;
    localparam int SHIFT_W = OFF_FRAC + GAIN_FRAC;

    localparam logic [COEF_W-1:0] GAIN_UNITY = COEF_W'(1) << GAIN_FRAC;

    localparam logic [ADDR_W-1:0] ADDR_GAIN_TIA = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_GAIN_AUX = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_OFF_AUX  = 2'd2;

    typedef enum logic {
        CH_TIA = 1'b0,
        CH_AUX = 1'b1
    } chan_e;

    typedef struct packed {
        logic                     valid;
        chan_e                    chan;
        logic [COEF_W-1:0]        gain;
        logic signed [EXT_W-1:0]  ext;
    } stage1_t;

    function automatic logic [SAMPLE_W-1:0] round_sat(input logic signed [PROD_W-1:0] p);
        logic [PROD_W-1:0]        mag;
        logic [PROD_W-1:0]        q;
        logic signed [PROD_W-1:0] r;
        logic                     neg;
        logic                     fits;
        neg  = p[PROD_W-1];
        mag  = neg ? PROD_W'(-p) : PROD_W'(p);
        q    = (mag + (PROD_W'(1) << (SHIFT_W-1))) >> SHIFT_W;
        r    = neg ? -$signed(q) : $signed(q);
        fits = (r[PROD_W-1:SAMPLE_W-1] == '0) || (r[PROD_W-1:SAMPLE_W-1] == '1);
        if (fits)
            return r[SAMPLE_W-1:0];
        else if (r[PROD_W-1])
            return {1'b1, {(SAMPLE_W-1){1'b0}}};
        else
            return {1'b0, {(SAMPLE_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/cal_coef_bank.sv
module cal_coef_bank
    import adccal_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [WORD_W-1:0]        reg_wdata,
    output logic [WORD_W-1:0]        reg_rdata,
    output logic [COEF_W-1:0]        gain_tia,
    output logic [COEF_W-1:0]        gain_aux,
    output logic [COEF_W-1:0]        off_aux
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_tia <= GAIN_UNITY;
            gain_aux <= GAIN_UNITY;
            off_aux  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_GAIN_TIA: gain_tia <= reg_wdata[COEF_W-1:0];
                ADDR_GAIN_AUX: gain_aux <= reg_wdata[COEF_W-1:0];
                ADDR_OFF_AUX:  off_aux  <= reg_wdata[COEF_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_GAIN_TIA: reg_rdata = WORD_W'(gain_tia);
            ADDR_GAIN_AUX: reg_rdata = WORD_W'(gain_aux);
            ADDR_OFF_AUX:  reg_rdata = WORD_W'(off_aux);
            default:       reg_rdata = '0;
        endcase
    end

    // R2: writes land at the next edge, low field only
    assert_wr_tia_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_GAIN_TIA) |=> gain_tia == $past(reg_wdata[COEF_W-1:0]));
    assert_wr_aux_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_GAIN_AUX) |=> gain_aux == $past(reg_wdata[COEF_W-1:0]));
    assert_wr_off_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_OFF_AUX) |=> off_aux == $past(reg_wdata[COEF_W-1:0]));

endmodule

// File: rtl/cal_offset_stage.sv
module cal_offset_stage
    import adccal_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  chan_e                      in_chan,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic [COEF_W-1:0]          gain_tia,
    input  logic [COEF_W-1:0]          gain_aux,
    input  logic [COEF_W-1:0]          off_aux,
    output stage1_t                    s1
);

    logic signed [EXT_W-1:0] sample_q;
    logic signed [EXT_W-1:0] off_ext;
    stage1_t                 nxt;

    always_comb begin
        sample_q  = EXT_W'(in_sample) <<< OFF_FRAC;
        off_ext   = (in_chan == CH_AUX) ? EXT_W'($signed(off_aux)) : '0;
        nxt.valid = in_valid;
        nxt.chan  = in_chan;
        nxt.gain  = (in_chan == CH_AUX) ? gain_aux : gain_tia;
        nxt.ext   = sample_q + off_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) begin
                s1.chan <= nxt.chan;
                s1.gain <= nxt.gain;
                s1.ext  <= nxt.ext;
            end
        end
    end

    // R9: acceptance advances the valid flag one stage
    assert_stage1_valid_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1.valid);
    // R4: transimpedance samples carry no offset
    assert_tia_no_offset_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_chan == CH_TIA) |=>
        s1.ext == {{(EXT_W-SAMPLE_W-OFF_FRAC){$past(in_sample[SAMPLE_W-1])}}, $past(in_sample), {OFF_FRAC{1'b0}}});

endmodule

// File: rtl/cal_scale_stage.sv
module cal_scale_stage
    import adccal_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  stage1_t             s1,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);

    logic signed [PROD_W-1:0] ext_w;
    logic signed [PROD_W-1:0] gain_w;
    logic signed [PROD_W-1:0] prod;
    logic [SAMPLE_W-1:0]      result;

    always_comb begin
        ext_w  = PROD_W'(s1.ext);
        gain_w = $signed(PROD_W'(s1.gain));
        prod   = ext_w * gain_w;
        if (s1.gain == '0)
            result = (s1.chan == CH_AUX) ? {1'b1, {(SAMPLE_W-1){1'b0}}} : '0;
        else
            result = round_sat(prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1.valid;
            if (s1.valid)
                out_data <= result;
        end
    end

    // R9: valid follows stage 1 by one edge, data holds when idle
    assert_out_valid_R9: assert property (@(posedge clk) disable iff (rst)
        s1.valid |=> out_valid);
    assert_out_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !s1.valid |=> (!out_valid && $stable(out_data)));
    // R8: zero gain code forces class constant
    assert_zero_gain_aux_R8: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && s1.gain == '0 && s1.chan == CH_AUX) |=> out_data == {1'b1, {(SAMPLE_W-1){1'b0}}});
    assert_zero_gain_tia_R8: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && s1.gain == '0 && s1.chan == CH_TIA) |=> out_data == '0);
    // R3: unity gain passes transimpedance samples through
    assert_unity_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && s1.gain == GAIN_UNITY && s1.chan == CH_TIA) |=>
        out_data == $past(s1.ext[OFF_FRAC +: SAMPLE_W]));

endmodule

// File: rtl/adc_cal_path.sv
module adc_cal_path
    import adccal_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [WORD_W-1:0]          reg_wdata,
    output logic [WORD_W-1:0]          reg_rdata,
    input  logic                       in_valid,
    input  logic                       in_chan,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic [SAMPLE_W-1:0]        out_data
);

    logic [COEF_W-1:0] gain_tia;
    logic [COEF_W-1:0] gain_aux;
    logic [COEF_W-1:0] off_aux;
    stage1_t           s1;
    chan_e             chan_tag;

    assign chan_tag = chan_e'(in_chan);

    cal_coef_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gain_tia  (gain_tia),
        .gain_aux  (gain_aux),
        .off_aux   (off_aux)
    );

    cal_offset_stage u_off (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_chan   (chan_tag),
        .in_sample (in_sample),
        .gain_tia  (gain_tia),
        .gain_aux  (gain_aux),
        .off_aux   (off_aux),
        .s1        (s1)
    );

    cal_scale_stage u_scale (
        .clk       (clk),
        .rst       (rst),
        .s1        (s1),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: tb/sim_adc_cal_path.sv
module sim_adc_cal_path;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic        in_chan = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit run    = 0;

    int m_gtia = 16'h4000;
    int m_gaux = 16'h4000;
    int m_oaux = 0;

    logic [15:0] exp_q[$];
    string       req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_cal_path u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_chan(in_chan), .in_sample(in_sample), .out_valid(out_valid),
        .out_data(out_data)
    );

    function automatic logic [15:0] model(int s, bit aux, int g, int o15);
        longint off, e, p, m, q;
        if (g == 0) return aux ? 16'h8000 : 16'h0000;
        off = 0;
        if (aux) off = (o15 >= 16384) ? o15 - 32768 : o15;
        e = longint'(s) * 4 + off;
        p = e * g;
        m = (p < 0) ? -p : p;
        q = (m + 32768) >>> 16;
        if (p < 0) q = -q;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        return 16'(q);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run && !rst && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 actual=unexpected out_valid expected=idle");
            end else begin
                logic [15:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(r, {16'h0, out_data}, {16'h0, e});
            end
        end
    end

    // one negedge step: sample snapshot uses coefficients before this write
    task automatic step(bit v, bit aux, int s, bit w, logic [1:0] a, logic [31:0] d, string req);
        @(negedge clk);
        if (v) begin
            exp_q.push_back(model(s, aux, aux ? m_gaux : m_gtia, m_oaux));
            req_q.push_back(req);
        end
        if (w) begin
            case (a)
                2'd0: m_gtia = int'(d[14:0]);
                2'd1: m_gaux = int'(d[14:0]);
                2'd2: m_oaux = int'(d[14:0]);
                default: ;
            endcase
        end
        in_valid  = v;
        in_chan   = aux;
        in_sample = 16'(s);
        reg_wr    = w;
        reg_addr  = a;
        reg_wdata = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'd3, 0, "");
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        step(0, 0, 0, 1, a, d, "");
    endtask

    task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        in_valid = 0; reg_wr = 0; reg_addr = a;
        #1 check(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        run = 1;
        #1 check("R9 reset", {31'h0, out_valid}, 32'h0);
        // R1 reset values
        rd(2'd0, 32'h4000, "R1");
        rd(2'd1, 32'h4000, "R1");
        rd(2'd2, 32'h0, "R1");
        rd(2'd3, 32'h0, "R1");
        // R2 only low field stored
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, 32'h7FFF, "R2");
        wr(2'd0, 32'hABCD_4000);
        rd(2'd0, 32'h4000, "R2");
        wr(2'd2, 32'h0);
        // R9 latency
        step(1, 0, 77, 0, 2'd3, 0, "R9");
        step(0, 0, 0, 0, 2'd3, 0, "");
        #1 check("R9 one edge", {31'h0, out_valid}, 32'h0);
        step(0, 0, 0, 0, 2'd3, 0, "");
        #1 check("R9 two edges", {31'h0, out_valid}, 32'h1);
        // R3 unity pass
        step(1, 0, 1234, 0, 2'd3, 0, "R3");
        step(1, 1, -1234, 0, 2'd3, 0, "R3");
        step(1, 1, -32768, 0, 2'd3, 0, "R3");
        // R4 offset weighting and TIA ignores offset
        wr(2'd2, 32'h0001);
        step(1, 1, 10, 0, 2'd3, 0, "R4");
        wr(2'd2, 32'h4000);
        step(1, 1, 100, 0, 2'd3, 0, "R4");
        step(1, 0, 100, 0, 2'd3, 0, "R4");
        wr(2'd2, 32'h3FFF);
        step(1, 1, 0, 0, 2'd3, 0, "R4");
        // R6 ties away from zero
        wr(2'd2, 32'h0002);
        step(1, 1, 10, 0, 2'd3, 0, "R6");
        wr(2'd2, 32'h7FFE);
        step(1, 1, -10, 0, 2'd3, 0, "R6");
        wr(2'd2, 32'h0);
        // R5 gain scaling
        wr(2'd0, 32'h2000);
        step(1, 0, 3, 0, 2'd3, 0, "R5 R6");
        step(1, 0, -3, 0, 2'd3, 0, "R5 R6");
        wr(2'd0, 32'h0001);
        step(1, 0, 32767, 0, 2'd3, 0, "R5");
        // R7 saturation
        wr(2'd1, 32'h7FFF);
        step(1, 1, 30000, 0, 2'd3, 0, "R7");
        step(1, 1, -30000, 0, 2'd3, 0, "R7");
        // R8 illegal zero gain
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0);
        step(1, 1, 555, 0, 2'd3, 0, "R8");
        step(1, 0, 555, 0, 2'd3, 0, "R8");
        // R10 snapshot at acceptance
        wr(2'd1, 32'h4000);
        step(1, 1, 100, 0, 2'd3, 0, "R10");
        step(1, 1, 100, 1, 2'd1, 32'h2000, "R10");
        step(1, 1, 100, 0, 2'd3, 0, "R10");
        step(1, 0, 100, 1, 2'd0, 32'h4000, "R10");
        step(1, 0, 100, 0, 2'd3, 0, "R10");
        idle(4);
        // constrained random stream, R5 R6 R7 model
        for (int i = 0; i < 800; i++) begin
            bit v, aux, w;
            int s;
            logic [1:0] a;
            logic [31:0] d;
            v   = ($urandom % 4) != 0;
            aux = $urandom % 2;
            s   = int'($signed(16'($urandom)));
            w   = ($urandom % 12) == 0;
            a   = 2'($urandom % 3);
            case ($urandom % 6)
                0: d = 32'h4000;
                1: d = 32'h7FFF;
                2: d = 32'h0001;
                3: d = 32'h2000;
                default: d = $urandom;
            endcase
            step(v, aux, s, w, w ? a : 2'd3, d, "R5 random");
        end
        idle(4);
        check("R9 drained", exp_q.size(), 0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule